// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block produces the framing conditions of an I2C transfer, namely START, repeated START and STOP, for a serial port that can work as either bus master or addressed slave. A host holds two request bits. One asks for a START and one asks for a STOP. The block turns those requests into timed open-drain pull-low controls on SCL and SDA. It also watches the bus lines through synchronizers so it can tell whether another master currently owns the bus.

A START request on a free bus is issued at once. On a busy bus the request waits for the STOP, then waits one more half serial-clock period before it drives anything. A STOP request in master mode drives a real STOP, and the STOP request is cleared when that condition is seen on the bus. A STOP request while not master drives nothing. It only resets the internal view of the bus and strobes a return to the unaddressed slave state. Byte shifting, address matching, arbitration and clock stretching belong to neighbouring logic. The block reports only that a START or a STOP has finished.

Top module: `i2c_cond_seq`

## Requirements
- R1: While `en_i` is 0 the block drives neither line low, keeps `busy_o` and `master_o` at 0 and issues no condition; a request left pending is served once `en_i` returns to 1.
- R2: With `sta_i` at 1 on a free bus, the block pulls SDA low with SCL released for HALF_CNT cycles, then also pulls SCL low; `start_done_o` pulses in the 2*HALF_CNT-th cycle after SDA was first pulled, and `master_o` becomes 1.
- R3: With `sta_i` at 1 while the bus is busy, nothing is driven until a STOP clears `busy_o`; SDA is pulled exactly HALF_CNT+1 cycles after `busy_o` falls.
- R4: In master mode, with `sta_i` and `byte_done_i` both at 1, the block releases SDA, then SCL, then issues a repeated START, and it stays master.
- R5: A START request raised while the block is an addressed slave (`slave_addr_i` at 1) on a busy bus stays pending without driving the bus, and it is issued after the bus is freed.
- R6: In master mode, with `sta_i` at 0 or `byte_done_i` at 0, and `sto_i` at 0, the block keeps both lines pulled low and issues no new condition.
- R7: With `sto_i` at 1 in master mode, the block drives a STOP. `sto_clr_o` and `stop_done_o` pulse in the cycle the STOP is detected. After that `busy_o` and `master_o` are 0.
- R8: With `sto_i` at 1 while not master, the block drives neither line. `sto_clr_o` and `unaddr_o` pulse together, and `busy_o` reads 0 in the following cycle.
- R9: With `sta_i` and `sto_i` both at 1 in master mode, a STOP appears on the bus before a new START. The START follows at least HALF_CNT cycles after the STOP.
- R10: `busy_o` is 0 after reset. It becomes 1 after any START is seen on the synchronized lines and returns to 0 after any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Interface enable |
| sta_i | input | 1 | Host START request bit |
| sto_i | input | 1 | Host STOP request bit |
| slave_addr_i | input | 1 | Port is currently an addressed slave |
| byte_done_i | input | 1 | At least one byte has been moved in this master transfer |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Bus held by some master |
| master_o | output | 1 | Port owns the bus |
| start_done_o | output | 1 | One-cycle pulse: START or repeated START finished |
| stop_done_o | output | 1 | One-cycle pulse: own STOP seen on the bus |
| sto_clr_o | output | 1 | One-cycle pulse telling the host to clear its STOP request |
| unaddr_o | output | 1 | One-cycle pulse: return to the unaddressed slave receiver state |

## Verification
The assertions assume that the host clears its STOP bit on the `sto_clr_o` pulse and its START bit on `start_done_o`. They also assume that no other agent changes SDA while SCL is high during this port's own conditions. The stimulus respects both points. The bench host register is cleared by those pulses, and the bench's other master only pulls the lines while this port is idle or waiting. The bench keeps its own START and STOP conditions slower than the synchronizer latency, so every edge it makes is detected.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_WAITF,
      S_GAP,
      S_STA_A,
      S_STA_B,
      S_HOLD,
      S_RS_A,
      S_RS_B,
      S_SP_A,
      S_SP_B,
      S_SP_C
   } seq_st_e;
endpackage

// File: rtl/i2c_cs_sync.sv
module i2c_cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_cs_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_cs_detect.sv
module i2c_cs_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic scl_s_i,
   input  logic sda_s_i,
   input  logic force_free_i,
   output logic start_det_o,
   output logic stop_det_o,
   output logic busy_o
);
   logic scl_d, sda_d, busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s_i;
         sda_d <= sda_s_i;
      end
   end

   assign start_det_o = scl_d & scl_s_i & sda_d & ~sda_s_i;
   assign stop_det_o  = scl_d & scl_s_i & ~sda_d & sda_s_i;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i)             busy_q <= 1'b0;
      else if (stop_det_o || force_free_i) busy_q <= 1'b0;
      else if (start_det_o)            busy_q <= 1'b1;
   end

   assign busy_o = busy_q;

   // R10: a START seen on the lines marks the bus busy
   p_busy_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && start_det_o && !force_free_i) |=> busy_o);
   // R10: a STOP seen on the lines marks the bus free
   p_free_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det_o |=> !busy_o);
endmodule

// File: rtl/i2c_cs_fsm.sv
module i2c_cs_fsm
   import i2c_cs_pkg::*;
#(
   parameter int HALF_CNT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sta_i,
   input  logic sto_i,
   input  logic addressed_i,
   input  logic byte_done_i,
   input  logic busy_i,
   input  logic stop_det_i,
   output logic scl_pull_o,
   output logic sda_pull_o,
   output logic master_o,
   output logic start_done_o,
   output logic stop_done_o,
   output logic sto_clr_o,
   output logic unaddr_o,
   output logic force_free_o
);
   localparam int CW = $clog2(HALF_CNT + 1);
   localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

   seq_st_e st_q, st_d;
   logic [CW-1:0] cnt_q;
   logic tmr_done, master_q, recover, bus_taken;

   assign tmr_done  = (cnt_q == LAST);
   assign bus_taken = busy_i | addressed_i;
   assign recover   = sto_i & ~master_q &
                      ((st_q == S_IDLE) | (st_q == S_WAITF) | (st_q == S_GAP));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:  if (recover)                 st_d = S_IDLE;
                  else if (sta_i)              st_d = bus_taken ? S_WAITF : S_STA_A;
         S_WAITF: if (recover || !sta_i)       st_d = S_IDLE;
                  else if (!bus_taken)         st_d = S_GAP;
         S_GAP:   if (recover || !sta_i)       st_d = S_IDLE;
                  else if (bus_taken)          st_d = S_WAITF;
                  else if (tmr_done)           st_d = S_STA_A;
         S_STA_A: if (tmr_done)                st_d = S_STA_B;
         S_STA_B: if (tmr_done)                st_d = S_HOLD;
         S_HOLD:  if (sto_i)                   st_d = S_SP_A;
                  else if (sta_i && byte_done_i) st_d = S_RS_A;
         S_RS_A:  if (tmr_done)                st_d = S_RS_B;
         S_RS_B:  if (tmr_done)                st_d = S_STA_A;
         S_SP_A:  if (tmr_done)                st_d = S_SP_B;
         S_SP_B:  if (tmr_done)                st_d = S_SP_C;
         S_SP_C:  if (stop_det_i)              st_d = sta_i ? S_GAP : S_IDLE;
         default:                              st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         st_q  <= S_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= (st_d != st_q) ? '0 : (tmr_done ? cnt_q : cnt_q + 1'b1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i)  master_q <= 1'b0;
      else if (stop_done_o) master_q <= 1'b0;
      else if (start_done_o) master_q <= 1'b1;
   end

   assign scl_pull_o = (st_q == S_STA_B) | (st_q == S_HOLD) |
                       (st_q == S_RS_A)  | (st_q == S_SP_A);
   assign sda_pull_o = (st_q == S_STA_A) | (st_q == S_STA_B) | (st_q == S_HOLD) |
                       (st_q == S_SP_A)  | (st_q == S_SP_B);
   assign master_o     = master_q;
   assign start_done_o = (st_q == S_STA_B) & tmr_done;
   assign stop_done_o  = (st_q == S_SP_C) & stop_det_i;
   assign sto_clr_o    = recover | stop_done_o;
   assign unaddr_o     = recover;
   assign force_free_o = recover;

   // R1: disabled port is silent one cycle later
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!scl_pull_o && !sda_pull_o && !master_o));
   // R2: idle request on a free bus opens a START at the next cycle
   p_free_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == S_IDLE && sta_i && !sto_i && !bus_taken) |=> (sda_pull_o && !scl_pull_o));
   // R3: a fresh (non-repeated) START only follows a free bus
   p_start_needs_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull_o) && !scl_pull_o && !master_q) |-> $past(!bus_taken));
   // R6: master holds both lines while nothing is requested
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == S_HOLD && !sto_i && !(sta_i && byte_done_i)) |=> (scl_pull_o && sda_pull_o));
   // R7: own STOP leaves a free bus and no mastership
   p_stop_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done_o |=> (!busy_i && !master_o));
   // R8: slave recovery drives nothing and frees the bus view
   p_recover_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      recover |-> (!scl_pull_o && !sda_pull_o));
   p_recover_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && recover) |=> !busy_i);
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
   parameter int HALF_CNT    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sta_i,
   input  logic sto_i,
   input  logic slave_addr_i,
   input  logic byte_done_i,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_pull_o,
   output logic sda_pull_o,
   output logic busy_o,
   output logic master_o,
   output logic start_done_o,
   output logic stop_done_o,
   output logic sto_clr_o,
   output logic unaddr_o
);
   generate
      if (HALF_CNT < SYNC_STAGES + 2) begin : g_bad_half
         $error("i2c_cond_seq: HALF_CNT must exceed the line detection latency");
      end
   endgenerate

   logic scl_s, sda_s, start_det, stop_det, busy, force_free;

   i2c_cs_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2c_cs_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_cs_detect u_detect (
      .clk(clk), .rst_n(rst_n), .en_i(en_i),
      .scl_s_i(scl_s), .sda_s_i(sda_s), .force_free_i(force_free),
      .start_det_o(start_det), .stop_det_o(stop_det), .busy_o(busy));

   i2c_cs_fsm #(.HALF_CNT(HALF_CNT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en_i(en_i),
      .sta_i(sta_i), .sto_i(sto_i), .addressed_i(slave_addr_i),
      .byte_done_i(byte_done_i), .busy_i(busy), .stop_det_i(stop_det),
      .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .master_o(master_o),
      .start_done_o(start_done_o), .stop_done_o(stop_done_o),
      .sto_clr_o(sto_clr_o), .unaddr_o(unaddr_o), .force_free_o(force_free));

   assign busy_o = busy;
endmodule

// File: tb/i2c_cond_seq_bench.sv
`timescale 1ns/1ps
module i2c_cond_seq_bench;
   localparam int HALF = 5;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, en, slave, byte_done;
   logic sta_set, sto_set, sta_q, sto_q;
   logic ext_scl, ext_sda;
   logic scl_pull, sda_pull, busy, master, start_done, stop_done, sto_clr, unaddr;
   logic scl_w, sda_w, pscl, psda;
   int tests = 0, fails = 0;
   int cyc = 0, n_start = 0, n_stop = 0, n_drive = 0, n_unaddr = 0, t_start = 0, t_stop = 0;

   assign scl_w = ~(scl_pull | ext_scl);
   assign sda_w = ~(sda_pull | ext_sda);

   i2c_cond_seq #(.HALF_CNT(HALF), .SYNC_STAGES(2)) u_i2c_cond_seq (
      .clk(clk), .rst_n(rst_n), .en_i(en), .sta_i(sta_q), .sto_i(sto_q),
      .slave_addr_i(slave), .byte_done_i(byte_done), .scl_i(scl_w), .sda_i(sda_w),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy), .master_o(master),
      .start_done_o(start_done), .stop_done_o(stop_done), .sto_clr_o(sto_clr),
      .unaddr_o(unaddr));

   // host request register model
   always @(posedge clk) begin
      if (!rst_n) begin
         sta_q <= 1'b0;
         sto_q <= 1'b0;
      end else begin
         if (sta_set) sta_q <= 1'b1; else if (start_done) sta_q <= 1'b0;
         if (sto_set) sto_q <= 1'b1; else if (sto_clr) sto_q <= 1'b0;
      end
   end

   // bus monitor
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (pscl && scl_w && psda && !sda_w) begin n_start = n_start + 1; t_start = cyc; end
      if (pscl && scl_w && !psda && sda_w) begin n_stop = n_stop + 1; t_stop = cyc; end
      if (scl_pull || sda_pull) n_drive = n_drive + 1;
      if (unaddr) n_unaddr = n_unaddr + 1;
      pscl = scl_w;
      psda = sda_w;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sta();
      @(negedge clk); sta_set = 1'b1; @(negedge clk); sta_set = 1'b0;
   endtask

   task automatic pulse_sto();
      @(negedge clk); sto_set = 1'b1; @(negedge clk); sto_set = 1'b0;
   endtask

   task automatic wait_start_done(output int n);
      n = 0;
      while (!start_done && n < 400) begin @(negedge clk); n++; end
   endtask

   task automatic wait_sto_clr(output int n);
      n = 0;
      while (!sto_clr && n < 400) begin @(negedge clk); n++; end
   endtask

   task automatic ext_start();
      @(negedge clk); ext_sda = 1'b1; tick(10); ext_scl = 1'b1; tick(10);
   endtask

   task automatic ext_stop();
      @(negedge clk); ext_sda = 1'b1; tick(10); ext_scl = 1'b0; tick(10); ext_sda = 1'b0; tick(10);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n, d0, s0, st0, u0;
      rst_n = 1'b0; en = 1'b0; slave = 1'b0; byte_done = 1'b0;
      sta_set = 1'b0; sto_set = 1'b0; ext_scl = 1'b0; ext_sda = 1'b0;
      pscl = 1'b1; psda = 1'b1;
      tick(5);
      chk(!scl_pull && !sda_pull && !busy && !master, "R1 reset state", {scl_pull, sda_pull, busy, master}, 0);
      chk(!busy, "R10 busy clear after reset", busy, 0);
      rst_n = 1'b1;

      // R1: disabled, request pending
      pulse_sta();
      tick(40);
      chk(n_drive == 0 && n_start == 0, "R1 no drive while disabled", n_drive, 0);

      // R2: enable serves the pending START on a free bus
      en = 1'b1;
      n = 0;
      while (!sda_pull && n < 50) begin @(negedge clk); n++; end
      chk(sda_pull && !scl_pull, "R2 SDA pulled first", {sda_pull, scl_pull}, 2);
      n = 1;
      @(negedge clk);
      while (!start_done && n < 100) begin @(negedge clk); n++; end
      chk(n == 2 * HALF - 1, "R2 start length", n, 2 * HALF - 1);
      tick(1);
      chk(master && busy && n_start == 1, "R2 master after START", {master, busy}, 3);

      // R6: no request, bus held
      tick(30);
      chk(scl_pull && sda_pull && n_start == 1, "R6 hold without request", n_start, 1);
      pulse_sta();
      tick(30);
      chk(n_start == 1 && scl_pull && sda_pull, "R6 no restart before a byte", n_start, 1);

      // R4: repeated START once a byte has moved
      byte_done = 1'b1;
      wait_start_done(n);
      chk(n < 400 && n_start == 2, "R4 repeated start issued", n_start, 2);
      tick(1);
      chk(master == 1'b1, "R4 still master", master, 1);
      byte_done = 1'b0;

      // R7: master STOP
      s0 = n_stop;
      pulse_sto();
      wait_sto_clr(n);
      chk(stop_done == 1'b1 && n < 400, "R7 stop_done with sto_clr", stop_done, 1);
      tick(2);
      chk(n_stop == s0 + 1, "R7 STOP on bus", n_stop, s0 + 1);
      chk(!busy && !master && !sto_q && !scl_pull && !sda_pull, "R7 free after stop",
          {busy, master, sto_q}, 0);

      // R10: another master's START and STOP
      ext_start();
      chk(busy == 1'b1, "R10 busy after foreign START", busy, 1);
      ext_stop();
      chk(busy == 1'b0, "R10 free after foreign STOP", busy, 0);

      // R3: request on busy bus waits for STOP plus gap
      ext_start();
      d0 = n_drive;
      pulse_sta();
      tick(60);
      chk(n_drive == d0, "R3 no drive while busy", n_drive - d0, 0);
      @(negedge clk); ext_scl = 1'b0; tick(10); ext_sda = 1'b0;
      n = 0;
      while (busy && n < 50) begin @(negedge clk); n++; end
      n = 0;
      while (!sda_pull && n < 50) begin @(negedge clk); n++; end
      chk(n == HALF + 1, "R3 gap after STOP", n, HALF + 1);
      wait_start_done(n);
      tick(1);
      chk(master == 1'b1, "R3 master after delayed START", master, 1);
      pulse_sto();
      wait_sto_clr(n);
      tick(3);

      // R5: request as addressed slave stays pending
      ext_start();
      slave = 1'b1;
      d0 = n_drive;
      pulse_sta();
      tick(60);
      chk(n_drive == d0 && !master && sta_q, "R5 pending as slave", n_drive - d0, 0);
      slave = 1'b0;
      st0 = n_start;
      ext_stop();
      wait_start_done(n);
      tick(1);
      chk(master && n_start == st0 + 1, "R5 pending START issued", n_start, st0 + 1);
      pulse_sto();
      wait_sto_clr(n);
      tick(3);

      // R8: STO as slave is a silent recovery
      ext_start();
      slave = 1'b1;
      d0 = n_drive; s0 = n_stop; u0 = n_unaddr;
      @(negedge clk); sto_set = 1'b1; @(negedge clk); sto_set = 1'b0;
      chk(sto_clr && unaddr, "R8 clear and unaddressed strobe", {sto_clr, unaddr}, 3);
      tick(2);
      chk(!busy && !sto_q, "R8 bus view freed", {busy, sto_q}, 0);
      chk(n_drive == d0 && n_stop == s0 && n_unaddr == u0 + 1, "R8 nothing driven",
          n_drive - d0, 0);
      slave = 1'b0;
      ext_stop();

      // R9: STA and STO together in master mode
      pulse_sta();
      wait_start_done(n);
      tick(1);
      s0 = n_stop; st0 = n_start;
      @(negedge clk); sta_set = 1'b1; sto_set = 1'b1;
      @(negedge clk); sta_set = 1'b0; sto_set = 1'b0;
      wait_sto_clr(n);
      wait_start_done(n);
      tick(1);
      chk(n_stop == s0 + 1 && n_start == st0 + 1, "R9 STOP and START both issued",
          n_start - st0, 1);
      chk(t_start - t_stop >= HALF, "R9 START after STOP with gap", t_start - t_stop, HALF);
      chk(master == 1'b1, "R9 master again", master, 1);

      // R1: disabling a master releases everything
      en = 1'b0;
      tick(2);
      chk(!scl_pull && !sda_pull && !master && !busy, "R1 disable releases", {scl_pull, sda_pull}, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule